// File: doc/BRIEF.md
# Error Locator Root Search Evaluator

The block takes an error locator polynomial of degree T over GF(2^M) and evaluates it at each of NPTS support elements, one point after another. For support index i it writes one bit to an error-vector memory: 1 when the polynomial is zero at that point, 0 otherwise. It reads the polynomial coefficients from an external coefficient memory while it evaluates, and the support elements from a second external memory. Both memories answer one cycle after an address is issued. The error vector leaves through a one-bit write port.

Two evaluation orders can be chosen at each start. Power-sum order (mode 0) keeps a running power of the point and a partial sum. It walks the coefficients from lowest to highest and uses two field multipliers. Nested order (mode 1) is Horner's rule. It walks the coefficients from highest to lowest and uses one multiplier and one accumulator. Both orders produce the same error vector but hold different intermediate values, so the mode bit may come from a random source for each decode. Field arithmetic reduces modulo a fixed polynomial given as a parameter.

The controller is a state machine with six states. IDLE goes to FETCH on start. FETCH (support and first coefficient addresses issued) goes to LOAD. LOAD goes to STEP. STEP repeats T times and then goes to WRITE. WRITE goes back to FETCH for the next point, or to DONE after the last point. DONE goes to IDLE.

Top module: `root_search_eval`

## Requirements
- R1: For every support index i in 0..NPTS-1, exactly one error-vector write occurs, at address i, in ascending order. The write carries 1 exactly when the polynomial evaluates to zero at the support element read from support address i.
- R2: With mode 0 the coefficient addresses in a point run 0,1,..,T. With mode 1 they run T,T-1,..,0. Each address is issued one cycle before its data is used.
- R3: Both modes give identical error vectors for the same coefficients and support.
- R4: Mode and start are sampled only in IDLE. Changing mode or pulsing start during a run has no effect on the result or the timing.
- R5: Each point takes T+3 cycles. done is a one-cycle pulse in the (NPTS*(T+3)+1)-th cycle counted from the clock edge that samples start, with that edge's cycle counted as 1. No two error writes occur in consecutive cycles.
- R6: After reset busy, done and err_we are 0.
- R7: An all-zero coefficient set flags every position.
- R8: A zero support element, repeated roots and a leading coefficient other than 1 are all handled. Arithmetic uses GF(2^M) modulo the parameter polynomial, which is x^5+x^2+1 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled in IDLE) |
| mode | input | 1 | 0 power-sum order, 1 nested order |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse after the last point |
| sup_addr | output | $clog2(NPTS) | Support memory address |
| sup_data | input | M | Support element, one cycle after its address |
| coef_addr | output | $clog2(T+1) | Coefficient memory address |
| coef_data | input | M | Coefficient, one cycle after its address |
| err_we | output | 1 | Error-vector write strobe |
| err_addr | output | $clog2(NPTS) | Error-vector write address |
| err_bit | output | 1 | 1 when the point is a root |

## Verification
On every cycle the assertions check the coefficient address order in each mode and that the held mode does not change during a run. They also check that done is a single pulse that directly follows the write to the last address, and that error writes are never adjacent. Only the bench scenarios can show the root decisions themselves. For those it builds polynomials from chosen roots, including zero, repeated roots and the zero polynomial, and compares the full error vector from both orders against the expected positions. The bench scenarios also show that mid-run changes to start and mode leave the result and the latency untouched.

// File: rtl/root_search_pkg.sv
package root_search_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_STEP,
        ST_WRITE,
        ST_DONE
    } rs_state_e;

    typedef enum logic {
        MODE_POWSUM = 1'b0,
        MODE_NEST   = 1'b1
    } rs_mode_e;
endpackage

// File: rtl/gf_mul.sv
module gf_mul #(
    parameter int         M   = 5,
    parameter logic [M-1:0] RED = 5'b00101
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] p
);
    logic [M-1:0] r;

    always_comb begin
        r = a[M-1] ? b : '0;
        for (int i = M - 1; i >= 1; i--) begin
            r = {r[M-2:0], 1'b0} ^ (r[M-1] ? RED : '0) ^ (a[i-1] ? b : '0);
        end
        p = r;
    end
endmodule

// File: rtl/rs_seq.sv
module rs_seq
    import root_search_pkg::*;
#(
    parameter int NPTS = 32,
    parameter int T    = 3,
    localparam int IW  = $clog2(NPTS),
    localparam int KW  = $clog2(T + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_in,
    output logic [IW-1:0] idx,
    output logic [KW-1:0] kk,
    output rs_mode_e      mode_r,
    output logic          fetch_o,
    output logic          load_o,
    output logic          step_o,
    output logic          write_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NPTS - 1);
    localparam logic [KW-1:0] LAST_K   = KW'(T);

    rs_state_e     state, nstate;
    logic [KW-1:0] k;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start) nstate = ST_FETCH;
            ST_FETCH: nstate = ST_LOAD;
            ST_LOAD:  nstate = ST_STEP;
            ST_STEP:  if (k == LAST_K) nstate = ST_WRITE;
            ST_WRITE: nstate = (idx == LAST_IDX) ? ST_DONE : ST_FETCH;
            ST_DONE:  nstate = ST_IDLE;
            default:  nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            k      <= '0;
            mode_r <= MODE_POWSUM;
        end else begin
            if (state == ST_IDLE && start) begin
                idx    <= '0;
                mode_r <= rs_mode_e'(mode_in);
            end
            if (state == ST_LOAD) k <= KW'(1);
            else if (state == ST_STEP) k <= k + 1'b1;
            if (state == ST_WRITE && idx != LAST_IDX) idx <= idx + 1'b1;
        end
    end

    always_comb begin
        fetch_o = 1'b0;
        load_o  = 1'b0;
        step_o  = 1'b0;
        write_o = 1'b0;
        busy_o  = 1'b1;
        done_o  = 1'b0;
        kk      = '0;
        unique case (state)
            ST_IDLE:  busy_o = 1'b0;
            ST_FETCH: fetch_o = 1'b1;
            ST_LOAD:  begin load_o = 1'b1; kk = KW'(1); end
            ST_STEP:  begin step_o = 1'b1; kk = k + 1'b1; end
            ST_WRITE: write_o = 1'b1;
            ST_DONE:  done_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_write_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        write_o |=> !write_o);

    assert_mode_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(mode_r));

    assert_done_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(write_o) && $past(idx) == LAST_IDX));
endmodule

// File: rtl/root_search_eval.sv
module root_search_eval
    import root_search_pkg::*;
#(
    parameter int           M    = 5,
    parameter int           T    = 3,
    parameter int           NPTS = 32,
    parameter logic [M-1:0] RED  = 5'b00101,
    localparam int          IW   = $clog2(NPTS),
    localparam int          CW   = $clog2(T + 1),
    localparam int          KW   = $clog2(T + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] sup_addr,
    input  logic [M-1:0]  sup_data,
    output logic [CW-1:0] coef_addr,
    input  logic [M-1:0]  coef_data,
    output logic          err_we,
    output logic [IW-1:0] err_addr,
    output logic          err_bit
);
    logic [IW-1:0] idx;
    logic [KW-1:0] kk;
    rs_mode_e      mode_r;
    logic          fetch_s, load_s, step_s, write_s;
    logic [M-1:0]  x_r, pw_r, acc_r;
    logic [M-1:0]  p0, p1, mul0_a;
    logic [KW-1:0] cidx;

    rs_seq #(.NPTS(NPTS), .T(T)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode_in(mode),
        .idx    (idx),
        .kk     (kk),
        .mode_r (mode_r),
        .fetch_o(fetch_s),
        .load_o (load_s),
        .step_o (step_s),
        .write_o(write_s),
        .busy_o (busy),
        .done_o (done)
    );

    // Shared multiplier: power advance (mode 0) or Horner step (mode 1)
    assign mul0_a = (mode_r == MODE_NEST) ? acc_r : pw_r;

    gf_mul #(.M(M), .RED(RED)) u_mul_pt (.a(mul0_a), .b(x_r), .p(p0));
    gf_mul #(.M(M), .RED(RED)) u_mul_cf (.a(coef_data), .b(p0), .p(p1));

    always_comb begin
        if (kk > KW'(T))              cidx = '0;
        else if (mode_r == MODE_NEST) cidx = KW'(T) - kk;
        else                          cidx = kk;
    end

    assign coef_addr = cidx[CW-1:0];
    assign sup_addr  = idx;
    assign err_we    = write_s;
    assign err_addr  = idx;
    assign err_bit   = (acc_r == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_r   <= '0;
            pw_r  <= '0;
            acc_r <= '0;
        end else if (load_s) begin
            x_r   <= sup_data;
            pw_r  <= M'(1);
            acc_r <= coef_data;
        end else if (step_s) begin
            if (mode_r == MODE_NEST) begin
                acc_r <= p0 ^ coef_data;
            end else begin
                pw_r  <= p0;
                acc_r <= acc_r ^ p1;
            end
        end
    end

    assert_up_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_s && kk <= KW'(T) && mode_r == MODE_POWSUM)
            |-> coef_addr == $past(coef_addr) + 1'b1);

    assert_down_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_s && kk <= KW'(T) && mode_r == MODE_NEST)
            |-> coef_addr == $past(coef_addr) - 1'b1);

    assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_s |-> coef_addr == ((mode_r == MODE_NEST) ? CW'(T) : CW'(0)));
endmodule

// File: tb/sim_root_search_eval.sv
module sim_root_search_eval;
    localparam int M    = 5;
    localparam int T    = 3;
    localparam int NPTS = 32;
    localparam int IW   = $clog2(NPTS);
    localparam int CW   = $clog2(T + 1);
    localparam int LAT  = NPTS * (T + 3) + 1;
    localparam int NV   = 6;
    // {scale, root_a, root_b, root_c}, 5 bits each; scale 0 means zero polynomial
    localparam logic [19:0] VEC [NV] = '{
        {5'd1,  5'd3,  5'd17, 5'd30},
        {5'd7,  5'd0,  5'd9,  5'd31},
        {5'd1,  5'd5,  5'd5,  5'd12},
        {5'd22, 5'd1,  5'd2,  5'd4},
        {5'd0,  5'd0,  5'd0,  5'd0},
        {5'd9,  5'd31, 5'd31, 5'd31}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
    logic busy, done, err_we, err_bit;
    logic [IW-1:0] sup_addr, err_addr;
    logic [CW-1:0] coef_addr;
    logic [M-1:0]  sup_data, coef_data;
    logic [M-1:0]  coef_mem [T+1];
    logic [M-1:0]  sup_mem  [NPTS];
    logic [NPTS-1:0] errv;
    int wcount = 0, ord_err = 0;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    root_search_eval #(.M(M), .T(T), .NPTS(NPTS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .busy(busy), .done(done),
        .sup_addr(sup_addr), .sup_data(sup_data),
        .coef_addr(coef_addr), .coef_data(coef_data),
        .err_we(err_we), .err_addr(err_addr), .err_bit(err_bit)
    );

    always @(posedge clk) begin
        coef_data <= coef_mem[coef_addr];
        sup_data  <= sup_mem[sup_addr];
        if (start && !busy) begin
            wcount  = 0;
            ord_err = 0;
            errv    = {NPTS/8{8'hA5}};
        end
        if (err_we) begin
            if (int'(err_addr) != wcount) ord_err++;
            errv[err_addr] = err_bit;
            wcount++;
        end
    end

    function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] res = '0;
        logic [M-1:0] sh  = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) res ^= sh;
            sh = sh[M-1] ? ((sh << 1) ^ 5'b00101) : (sh << 1);
        end
        return res;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_poly(input logic [19:0] v, output logic [NPTS-1:0] expv);
        logic [M-1:0] c [T+1];
        logic [M-1:0] s = v[19:15];
        logic [M-1:0] rt [3];
        rt[0] = v[14:10]; rt[1] = v[9:5]; rt[2] = v[4:0];
        for (int j = 0; j <= T; j++) c[j] = (j == 0) ? M'(1) : '0;
        for (int r = 0; r < 3; r++)
            for (int j = T; j >= 0; j--)
                c[j] = ((j > 0) ? c[j-1] : '0) ^ fmul(rt[r], c[j]);
        for (int j = 0; j <= T; j++) coef_mem[j] = fmul(s, c[j]);
        if (s == '0) expv = '1;
        else begin
            expv = '0;
            for (int r = 0; r < 3; r++) expv[rt[r]] = 1'b1;
        end
    endtask

    task automatic run(input logic md, input bit disturb, output int lat);
        @(negedge clk);
        mode = md; start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 4 * LAT) begin
            if (disturb && lat == 20) begin start = 1'b1; mode = ~md; end
            if (disturb && lat == 21) start = 1'b0;
            if (disturb && lat == 100) begin start = 1'b1; end
            if (disturb && lat == 101) begin start = 1'b0; mode = md; end
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        mode = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NPTS-1:0] expv, res0;
        int lat;
        for (int i = 0; i < NPTS; i++) sup_mem[i] = M'(i);
        for (int j = 0; j <= T; j++) coef_mem[j] = '0;
        repeat (3) @(negedge clk);
        // R6 reset values
        check(busy == 1'b0 && done == 1'b0 && err_we == 1'b0, "R6", "reset outputs",
              {busy, done, err_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R6", "idle after reset", busy, 0);

        for (int v = 0; v < NV; v++) begin
            load_poly(VEC[v], expv);
            for (int md = 0; md < 2; md++) begin
                run(md[0], 1'b0, lat);
                // R1 R7 R8: root positions
                check(errv == expv, (VEC[v][19:15] == 0) ? "R7" : "R1/R8",
                      $sformatf("error vector vec %0d mode %0d", v, md), errv, expv);
                check(lat == LAT, "R5", "done latency", lat, LAT);
                check(wcount == NPTS && ord_err == 0, "R1", "write count/order",
                      wcount, NPTS);
                if (md == 0) res0 = errv;
                else check(errv == res0, "R3", "modes agree", errv, res0);
            end
        end

        // R4: start and mode disturbed mid-run
        load_poly(VEC[0], expv);
        for (int md = 0; md < 2; md++) begin
            run(md[0], 1'b1, lat);
            check(errv == expv, "R4", "result with mid-run disturbance", errv, expv);
            check(lat == LAT, "R4", "latency with mid-run disturbance", lat, LAT);
        end
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R5", "done single pulse", done, 0);

        // R2: first coefficient address per mode, observed at FETCH (cycle after start edge)
        for (int md = 0; md < 2; md++) begin
            @(negedge clk);
            mode = md[0]; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(int'(coef_addr) == (md ? T : 0), "R2", "first coefficient address",
                  coef_addr, md ? T : 0);
            while (!done) @(negedge clk);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule